// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block keeps the time of day and a one-hundred-year calendar. Each one-cycle pulse on `tick` stands for one elapsed second; on that edge it advances seconds, minutes, hours, day of week, date, month and a two-digit year, with carries through month ends and leap Februaries. Software reaches the fields through a byte-wide write port and a combinational read port addressed by `wr_addr` and `rd_addr`.

Three static mode inputs set the view: `bin_mode` picks plain binary or packed BCD for every byte that is read or written, `h24_mode` picks a 24-hour or 12-hour hours byte, and `dst_en` turns on the spring-forward and fall-back corrections. The counters themselves are held in binary, so a mode change takes effect on the very next read. Alarm bytes are stored exactly as written and compared against the newly advanced time in the current format. Any of them can be made a wildcard, so the alarm can fire once per second, per minute, per hour or per day.

Each tick produces a one-cycle `update_evt`. When the new time matches the alarm, `alarm_evt` pulses in the same cycle.

Top module: `cal_clock`

## Requirements
- R1: After reset the fields read as time 00:00:00, day of week 1, date 1, month 1, year 0, all three alarm bytes 0x00, and both event outputs are low.
- R2: Each tick increments seconds. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours (internally 0..23) wrap from 23 to 0 and carry into the date.
- R3: Day of week counts 1..7 and advances on the midnight rollover, going from 7 back to 1.
- R4: The date rolls to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months. The month then advances, with month 12 going to 1 and advancing the year. Year 99 goes to 0.
- R5: February has 29 days when the year is divisible by 4, and 28 days otherwise.
- R6: The field addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes and 9 alarm hours. With `bin_mode`=1 bytes are plain binary; with `bin_mode`=0 they are BCD, tens in bits 7:4 and units in bits 3:0. This applies to both reads and writes.
- R7: With `h24_mode`=0 the hours byte holds 1..12 in bits 6:0, and bit 7 is set for PM (internal hours 12..23). Internal hour 0 reads as 12 AM, and a written 12 AM sets hour 0.
- R8: `alarm_evt` pulses together with `update_evt` when the updated seconds, minutes and hours bytes, in the current format, equal the alarm bytes. An alarm byte whose bits 7:6 are both 1 matches any value.
- R9: `update_evt` is high for exactly the one cycle after each cycle in which `tick` is high.
- R10: With `dst_en`=1, on a Sunday (day of week 1) with date 1..7 in month 4, a tick at 01:59:59 goes to 03:00:00.
- R11: With `dst_en`=1, on a Sunday with date 25 or later in month 10, the first tick at 01:59:59 goes back to 01:00:00, and the next pass through 01:59:59 goes on to 02:00:00. With `dst_en`=0 neither correction happens.
- R12: A write that lands in the same cycle as a tick sets its field to the written value, overriding the advance of that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write field address |
| wr_data | input | 8 | Write byte in the current format |
| rd_addr | input | 4 | Read field address |
| rd_data | output | 8 | Combinational read byte in the current format |
| bin_mode | input | 1 | 1 selects binary, 0 selects BCD |
| h24_mode | input | 1 | 1 selects 24-hour, 0 selects 12-hour with PM flag |
| dst_en | input | 1 | Enables the daylight-saving corrections |
| update_evt | output | 1 | Pulse after each tick update |
| alarm_evt | output | 1 | Pulse when the updated time matches the alarm |

## Verification
The counters, `update_evt` and `alarm_evt` are registered on the edge that samples `tick` or `wr_en`. That puts each of them one cycle after the stimulus. `rd_data` is combinational from the registered fields, so a read follows the same one-cycle latency. The bench drives inputs on the falling edge and releases them on the next falling edge, by which time the rising edge in between has registered the result. Events and read-back fields are sampled there, with the read address settled a fraction of the half period earlier.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int FLD_W  = 7;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int N_ALM  = 3;

    typedef logic [FLD_W-1:0]  fld_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        fld_t sec;
        fld_t min;
        fld_t hr;
        fld_t dow;
        fld_t date;
        fld_t mon;
        fld_t year;
    } tod_t;

    localparam logic [ADDR_W-1:0] AD_SEC  = 4'd0;
    localparam logic [ADDR_W-1:0] AD_MIN  = 4'd1;
    localparam logic [ADDR_W-1:0] AD_HR   = 4'd2;
    localparam logic [ADDR_W-1:0] AD_DOW  = 4'd3;
    localparam logic [ADDR_W-1:0] AD_DATE = 4'd4;
    localparam logic [ADDR_W-1:0] AD_MON  = 4'd5;
    localparam logic [ADDR_W-1:0] AD_YEAR = 4'd6;
    localparam logic [ADDR_W-1:0] AD_ALM0 = 4'd7;

    // binary value to output byte in the selected format
    function automatic byte_t enc(fld_t v, logic bin);
        byte_t tens, ones, res;
        tens = byte_t'(v / 7'd10);
        ones = byte_t'(v % 7'd10);
        res  = bin ? {1'b0, v} : ((tens << 4) | ones);
        return res;
    endfunction

    // written byte to binary value
    function automatic fld_t dec(byte_t d, logic bin);
        byte_t s;
        fld_t  res;
        s   = {4'd0, d[7:4]} * 8'd10 + {4'd0, d[3:0]};
        res = bin ? d[6:0] : s[6:0];
        return res;
    endfunction

    function automatic byte_t enc_hr(fld_t h, logic bin, logic h24);
        fld_t  h12;
        logic  pm;
        byte_t t, res;
        pm  = (h >= 7'd12);
        h12 = pm ? h - 7'd12 : h;
        if (h12 == 7'd0) h12 = 7'd12;
        t   = enc(h12, bin);
        res = h24 ? enc(h, bin) : {pm, t[6:0]};
        return res;
    endfunction

    function automatic fld_t dec_hr(byte_t d, logic bin, logic h24);
        fld_t h12, res;
        h12 = dec({1'b0, d[6:0]}, bin);
        if (h12 == 7'd12) h12 = 7'd0;
        res = h24 ? dec(d, bin) : (d[7] ? h12 + 7'd12 : h12);
        return res;
    endfunction
endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
    import cal_pkg::*;
#(
    parameter int LEAP_EVERY = 4
) (
    input  fld_t mon,
    input  fld_t year,
    output fld_t days
);
    localparam fld_t LEAP_M = fld_t'(LEAP_EVERY);

    logic leap;
    assign leap = ((year % LEAP_M) == 7'd0);

    always_comb begin
        case (mon)
            7'd2:                    days = leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11: days = 7'd30;
            default:                 days = 7'd31;
        endcase
    end
endmodule

// File: rtl/cal_step.sv
module cal_step
    import cal_pkg::*;
(
    input  tod_t cur,
    input  logic dst_en,
    input  logic fall_done,
    output tod_t nxt,
    output logic fall_hit
);
    fld_t mlen;
    logic at_159, sunday, spring, fall;

    cal_month_len #(.LEAP_EVERY(4)) i_mlen (
        .mon  (cur.mon),
        .year (cur.year),
        .days (mlen)
    );

    assign at_159 = (cur.hr == 7'd1) && (cur.min == 7'd59) && (cur.sec == 7'd59);
    assign sunday = (cur.dow == 7'd1);
    assign spring = dst_en && at_159 && sunday && (cur.mon == 7'd4) && (cur.date <= 7'd7);
    assign fall   = dst_en && at_159 && sunday && (cur.mon == 7'd10) && (cur.date >= 7'd25)
                    && !fall_done;

    always_comb begin
        nxt      = cur;
        fall_hit = 1'b0;
        if (spring) begin
            nxt.sec = 7'd0;
            nxt.min = 7'd0;
            nxt.hr  = 7'd3;
        end else if (fall) begin
            nxt.sec  = 7'd0;
            nxt.min  = 7'd0;
            nxt.hr   = 7'd1;
            fall_hit = 1'b1;
        end else if (cur.sec < 7'd59) begin
            nxt.sec = cur.sec + 7'd1;
        end else begin
            nxt.sec = 7'd0;
            if (cur.min < 7'd59) begin
                nxt.min = cur.min + 7'd1;
            end else begin
                nxt.min = 7'd0;
                if (cur.hr < 7'd23) begin
                    nxt.hr = cur.hr + 7'd1;
                end else begin
                    nxt.hr  = 7'd0;
                    nxt.dow = (cur.dow >= 7'd7) ? 7'd1 : cur.dow + 7'd1;
                    if (cur.date < mlen) begin
                        nxt.date = cur.date + 7'd1;
                    end else begin
                        nxt.date = 7'd1;
                        if (cur.mon < 7'd12) begin
                            nxt.mon = cur.mon + 7'd1;
                        end else begin
                            nxt.mon  = 7'd1;
                            nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import cal_pkg::*;
#(
    parameter int N_FLD = N_ALM,
    parameter logic [ADDR_W-1:0] BASE = AD_ALM0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  byte_t                   wr_data,
    input  logic [N_FLD-1:0][BYTE_W-1:0] cand,
    output logic [N_FLD-1:0][BYTE_W-1:0] regs,
    output logic                    hit
);
    logic [N_FLD-1:0][BYTE_W-1:0] alm_d, alm_q;
    logic [N_FLD-1:0]             fld_ok;

    always_comb begin
        alm_d = alm_q;
        for (int i = 0; i < N_FLD; i++) begin
            if (wr_en && (wr_addr == BASE + ADDR_W'(i))) alm_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) alm_q <= '0;
        else        alm_q <= alm_d;
    end

    for (genvar g = 0; g < N_FLD; g++) begin : g_cmp
        assign fld_ok[g] = (alm_q[g][7:6] == 2'b11) || (alm_q[g] == cand[g]);
    end

    assign hit  = &fld_ok;
    assign regs = alm_q;
endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [3:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        bin_mode,
    input  logic        h24_mode,
    input  logic        dst_en,
    output logic        update_evt,
    output logic        alarm_evt
);
    typedef struct packed {
        tod_t tod;
        logic fall;
        logic upd;
        logic alm;
    } st_t;

    localparam tod_t TOD_RST = '{sec: 7'd0, min: 7'd0, hr: 7'd0, dow: 7'd1,
                                 date: 7'd1, mon: 7'd1, year: 7'd0};

    st_t  st_d, st_q;
    tod_t stepped;
    logic fall_hit, alarm_hit;
    logic [N_ALM-1:0][BYTE_W-1:0] cand, alm_regs;

    cal_step i_step (
        .cur       (st_q.tod),
        .dst_en    (dst_en),
        .fall_done (st_q.fall),
        .nxt       (stepped),
        .fall_hit  (fall_hit)
    );

    assign cand[0] = enc(stepped.sec, bin_mode);
    assign cand[1] = enc(stepped.min, bin_mode);
    assign cand[2] = enc_hr(stepped.hr, bin_mode, h24_mode);

    cal_alarm #(.N_FLD(N_ALM), .BASE(AD_ALM0)) i_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cand    (cand),
        .regs    (alm_regs),
        .hit     (alarm_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upd = tick;
        st_d.alm = tick && alarm_hit;
        if (tick) st_d.tod = stepped;
        if (tick && fall_hit)           st_d.fall = 1'b1;
        else if (st_q.tod.hr != 7'd1)   st_d.fall = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                AD_SEC:  st_d.tod.sec  = dec(wr_data, bin_mode);
                AD_MIN:  st_d.tod.min  = dec(wr_data, bin_mode);
                AD_HR:   st_d.tod.hr   = dec_hr(wr_data, bin_mode, h24_mode);
                AD_DOW:  st_d.tod.dow  = dec(wr_data, bin_mode);
                AD_DATE: st_d.tod.date = dec(wr_data, bin_mode);
                AD_MON:  st_d.tod.mon  = dec(wr_data, bin_mode);
                AD_YEAR: st_d.tod.year = dec(wr_data, bin_mode);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{tod: TOD_RST, fall: 1'b0, upd: 1'b0, alm: 1'b0};
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_addr)
            AD_SEC:  rd_data = enc(st_q.tod.sec, bin_mode);
            AD_MIN:  rd_data = enc(st_q.tod.min, bin_mode);
            AD_HR:   rd_data = enc_hr(st_q.tod.hr, bin_mode, h24_mode);
            AD_DOW:  rd_data = enc(st_q.tod.dow, bin_mode);
            AD_DATE: rd_data = enc(st_q.tod.date, bin_mode);
            AD_MON:  rd_data = enc(st_q.tod.mon, bin_mode);
            AD_YEAR: rd_data = enc(st_q.tod.year, bin_mode);
            4'd7:    rd_data = alm_regs[0];
            4'd8:    rd_data = alm_regs[1];
            4'd9:    rd_data = alm_regs[2];
            default: rd_data = '0;
        endcase
    end

    assign update_evt = st_q.upd;
    assign alarm_evt  = st_q.alm;

    // R2: a plain tick moves seconds up by one
    p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && st_q.tod.sec < 7'd58) |=> (st_q.tod.sec == $past(st_q.tod.sec) + 7'd1));

    // R3: day of week wraps to 1 at midnight
    p_dow_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && st_q.tod.dow == 7'd7 && st_q.tod.hr == 7'd23
         && st_q.tod.min == 7'd59 && st_q.tod.sec == 7'd59) |=> (st_q.tod.dow == 7'd1));

    // R4: end of century rolls the year to 0
    p_year_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && st_q.tod.year == 7'd99 && st_q.tod.mon == 7'd12
         && st_q.tod.date == 7'd31 && st_q.tod.hr == 7'd23 && st_q.tod.min == 7'd59
         && st_q.tod.sec == 7'd59) |=> (st_q.tod.year == 7'd0 && st_q.tod.mon == 7'd1));

    // R8: an alarm only comes with an update
    p_alarm_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |-> update_evt);

    // R9: every update changes the held time
    p_upd_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (update_evt && !$past(wr_en)) |-> (st_q.tod != $past(st_q.tod)));
endmodule

// File: tb/test_cal_clock.sv
module test_cal_clock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       bin_mode = 1'b1;
    logic       h24_mode = 1'b1;
    logic       dst_en = 1'b0;
    logic       update_evt, alarm_evt;

    int total = 0;
    int bad   = 0;

    cal_clock i_cal_clock (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .bin_mode(bin_mode),
        .h24_mode(h24_mode), .dst_en(dst_en), .update_evt(update_evt), .alarm_evt(alarm_evt)
    );

    always #5 clk = ~clk;

    // start sec,min,hr,dow,date,mon,year then expected after one tick
    localparam logic [97:0] VEC [12] = '{
        {7'd30,7'd20,7'd10,7'd3,7'd5,7'd6,7'd21,  7'd31,7'd20,7'd10,7'd3,7'd5,7'd6,7'd21},
        {7'd59,7'd20,7'd10,7'd3,7'd5,7'd6,7'd21,  7'd0,7'd21,7'd10,7'd3,7'd5,7'd6,7'd21},
        {7'd59,7'd59,7'd10,7'd3,7'd5,7'd6,7'd21,  7'd0,7'd0,7'd11,7'd3,7'd5,7'd6,7'd21},
        {7'd59,7'd59,7'd23,7'd7,7'd10,7'd3,7'd21, 7'd0,7'd0,7'd0,7'd1,7'd11,7'd3,7'd21},
        {7'd59,7'd59,7'd23,7'd2,7'd30,7'd4,7'd21, 7'd0,7'd0,7'd0,7'd3,7'd1,7'd5,7'd21},
        {7'd59,7'd59,7'd23,7'd4,7'd31,7'd1,7'd21, 7'd0,7'd0,7'd0,7'd5,7'd1,7'd2,7'd21},
        {7'd59,7'd59,7'd23,7'd1,7'd28,7'd2,7'd23, 7'd0,7'd0,7'd0,7'd2,7'd1,7'd3,7'd23},
        {7'd59,7'd59,7'd23,7'd5,7'd28,7'd2,7'd24, 7'd0,7'd0,7'd0,7'd6,7'd29,7'd2,7'd24},
        {7'd59,7'd59,7'd23,7'd6,7'd29,7'd2,7'd24, 7'd0,7'd0,7'd0,7'd7,7'd1,7'd3,7'd24},
        {7'd59,7'd59,7'd23,7'd7,7'd31,7'd12,7'd99,7'd0,7'd0,7'd0,7'd1,7'd1,7'd1,7'd0},
        {7'd59,7'd59,7'd23,7'd3,7'd30,7'd9,7'd22,  7'd0,7'd0,7'd0,7'd4,7'd1,7'd10,7'd22},
        {7'd59,7'd59,7'd23,7'd3,7'd30,7'd7,7'd22,  7'd0,7'd0,7'd0,7'd4,7'd31,7'd7,7'd22}
    };

    task automatic check(input string req, input logic [97:0] act, input logic [97:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic tick_once(output logic upd, output logic alm);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        upd = update_evt;
        alm = alarm_evt;
    endtask

    task automatic set_time(input logic [6:0] f [7]);
        for (int i = 0; i < 7; i++) wr(4'(i), {1'b0, f[i]});
    endtask

    task automatic get_time(output logic [48:0] t);
        logic [7:0] v;
        for (int i = 0; i < 7; i++) begin
            rd(4'(i), v);
            t[48-7*i -: 7] = v[6:0];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [48:0] t;
        logic [7:0]  v;
        logic        u, a;
        logic [6:0]  f [7];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        get_time(t);
        check("R1 time", 98'(t), 98'({7'd0,7'd0,7'd0,7'd1,7'd1,7'd1,7'd0}));
        rd(4'd7, v); check("R1 alarm byte", 98'(v), 98'(0));
        rd(4'd9, v); check("R1 alarm byte", 98'(v), 98'(0));
        check("R1 events", 98'({update_evt, alarm_evt}), 98'(0));

        // table: R2 R3 R4 R5 carries, month ends and leap years
        for (int k = 0; k < 12; k++) begin
            for (int i = 0; i < 7; i++) f[i] = VEC[k][97-7*i -: 7];
            set_time(f);
            tick_once(u, a);
            get_time(t);
            check($sformatf("R2 R3 R4 R5 vector %0d", k), 98'(t), 98'(VEC[k][48:0]));
            check("R9 update pulse", 98'(u), 98'(1));
        end
        // R9 pulse lasts one cycle
        @(negedge clk);
        check("R9 update low", 98'(update_evt), 98'(0));

        // R6 BCD format
        bin_mode = 1'b0;
        wr(4'd0, 8'h45);
        rd(4'd0, v); check("R6 bcd read", 98'(v), 98'(8'h45));
        wr(4'd6, 8'h99);
        bin_mode = 1'b1;
        rd(4'd0, v); check("R6 binary view", 98'(v), 98'(8'h2D));
        rd(4'd6, v); check("R6 binary year", 98'(v), 98'(8'd99));

        // R7 twelve-hour view and writes
        h24_mode = 1'b0; bin_mode = 1'b0;
        wr(4'd2, 8'h12);           // 12 AM
        h24_mode = 1'b1; bin_mode = 1'b1;
        rd(4'd2, v); check("R7 12AM write", 98'(v), 98'(0));
        h24_mode = 1'b0; bin_mode = 1'b0;
        rd(4'd2, v); check("R7 midnight read", 98'(v), 98'(8'h12));
        wr(4'd2, 8'h92);           // 12 PM
        h24_mode = 1'b1; bin_mode = 1'b1;
        rd(4'd2, v); check("R7 12PM write", 98'(v), 98'(12));
        wr(4'd2, 8'd23);
        h24_mode = 1'b0;
        rd(4'd2, v); check("R7 23h binary", 98'(v), 98'(8'h8B));
        bin_mode = 1'b0;
        wr(4'd2, 8'h81);
        h24_mode = 1'b1;
        rd(4'd2, v); check("R7 1PM write", 98'(v), 98'(8'h13));
        bin_mode = 1'b1;

        // R8 alarm exact match
        f = '{7'd29, 7'd20, 7'd10, 7'd3, 7'd5, 7'd6, 7'd21};
        set_time(f);
        wr(4'd7, 8'd30); wr(4'd8, 8'd20); wr(4'd9, 8'd10);
        tick_once(u, a); check("R8 alarm match", 98'({u, a}), 98'(2'b11));
        tick_once(u, a); check("R8 alarm miss", 98'({u, a}), 98'(2'b10));
        // R8 wildcard on every field
        wr(4'd7, 8'hC0); wr(4'd8, 8'hC0); wr(4'd9, 8'hC0);
        tick_once(u, a); check("R8 wildcard", 98'(a), 98'(1));
        // R8 hour wildcard, minute mismatch
        wr(4'd8, 8'd50);
        tick_once(u, a); check("R8 partial wildcard", 98'(a), 98'(0));
        // no tick means no event
        @(negedge clk);
        check("R8 R9 idle", 98'({update_evt, alarm_evt}), 98'(0));

        // R10 spring forward
        dst_en = 1'b1;
        f = '{7'd59, 7'd59, 7'd1, 7'd1, 7'd5, 7'd4, 7'd21};
        set_time(f);
        tick_once(u, a);
        get_time(t);
        check("R10 spring", 98'(t), 98'({7'd0,7'd0,7'd3,7'd1,7'd5,7'd4,7'd21}));

        // R11 fall back once
        f = '{7'd59, 7'd59, 7'd1, 7'd1, 7'd27, 7'd10, 7'd21};
        set_time(f);
        tick_once(u, a);
        get_time(t);
        check("R11 fall back", 98'(t), 98'({7'd0,7'd0,7'd1,7'd1,7'd27,7'd10,7'd21}));
        wr(4'd1, 8'd59); wr(4'd0, 8'd59);
        tick_once(u, a);
        get_time(t);
        check("R11 second pass", 98'(t), 98'({7'd0,7'd0,7'd2,7'd1,7'd27,7'd10,7'd21}));

        // R11 disabled
        dst_en = 1'b0;
        f = '{7'd59, 7'd59, 7'd1, 7'd1, 7'd5, 7'd4, 7'd21};
        set_time(f);
        tick_once(u, a);
        rd(4'd2, v); check("R11 dst off", 98'(v), 98'(2));

        // R12 write and tick together
        wr(4'd0, 8'd10);
        wr(4'd1, 8'd7);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'd40;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(4'd0, v); check("R12 write wins", 98'(v), 98'(40));
        rd(4'd1, v); check("R12 other field", 98'(v), 98'(7));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule